// File: doc/BRIEF.md
# Atomic Lock Prefix Controller

This block sits behind the instruction decoder and decides what happens when an instruction asks to run atomically. Each accepted decode strobe carries an operation class, a flag that the lock prefix byte (0xF0, which has no operands of its own) was present, flags saying whether the destination and the source are memory operands, and a hint that the target line is already held in the internal cache. From these the block either raises an undefined-opcode fault, holds a lock for the whole life of the instruction, or does nothing.

A legal locked instruction gets one of two kinds of lock. If the target line is cached, a cache-line lock is held and the external bus lock stays released. Otherwise the active-low external bus lock is driven. The lock is taken when the instruction is accepted and is held until that instruction's retire strobe. While a lock is held, the block lowers its ready output, so the next instruction waits. A retire and the next decode strobe may fall in the same cycle.

The processor mode and the operand alignment reach the block but never change its verdict.

Top module: `atomic_lock_ctrl`

## Requirements
- R1: While reset is active and just after it, lock_n is 1, cache_lock is 0, ud_fault is 0 and dec_ready is 1.
- R2: The operation class codes 0 to 18 form the lockable set and codes 19 to 31 do not. A prefixed instruction with a lockable code, dst_mem=1 and src_mem=0 takes a lock in the cycle after it is accepted and raises no fault.
- R3: A prefixed instruction whose code lies outside the lockable set raises ud_fault for exactly the cycle in which its strobe is accepted, and it never takes a lock.
- R4: A prefixed instruction with a lockable code but dst_mem=0 or src_mem=1 raises ud_fault in its accept cycle and takes no lock.
- R5: Code 18 is exchange. Without the prefix, it takes a lock when dst_mem or src_mem is 1. Any other instruction without the prefix never locks and never faults.
- R6: When line_cached=1 a granted lock drives cache_lock=1 with lock_n=1. When line_cached=0 it drives lock_n=0 with cache_lock=0. The two are never active together.
- R7: A lock taken stays unchanged until retire is seen, and it is released in the cycle after retire.
- R8: While a lock is held and retire is low, dec_ready is 0. A strobe that arrives in the same cycle as retire is accepted, and its own outcome appears in the next cycle.
- R9: The values of cpu_mode and misaligned have no effect on ud_fault, lock_n or cache_lock.
- R10: A strobe raised while dec_ready is 0 is ignored and produces no fault. A retire raised while no lock is held has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dec_valid | input | 1 | Decoded instruction strobe |
| dec_ready | output | 1 | Block can accept a strobe this cycle |
| op_class | input | 5 | Decoded operation class code |
| lock_pfx | input | 1 | Lock prefix byte was present |
| dst_mem | input | 1 | Destination operand is in memory |
| src_mem | input | 1 | Source operand is in memory |
| line_cached | input | 1 | Target line is held in the internal cache |
| cpu_mode | input | 3 | Processor mode (ignored) |
| misaligned | input | 1 | Operand crosses an alignment boundary (ignored) |
| retire | input | 1 | Current instruction completes |
| lock_n | output | 1 | External bus lock, active low |
| cache_lock | output | 1 | Internal cache-line lock |
| ud_fault | output | 1 | Undefined-opcode fault pulse |

## Verification
Two functions can fall in the same cycle: the release of a held lock on retire, and the acceptance of the next decoded instruction. The bench holds a bus lock, raises an illegal prefixed strobe while retire is low and confirms that the strobe is ignored. It then raises retire together with that strobe and expects the fault pulse in that cycle and both locks released in the next. A second case pairs retire with a legal cached instruction and expects the lock to pass straight from the bus to the cache line, with no idle cycle between.

// File: rtl/atomic_lock_pkg.sv
package atomic_lock_pkg;
  localparam int OP_W          = 5;
  localparam int OP_COUNT      = 1 << OP_W;
  localparam int LOCKABLE_LAST = 18;
  localparam int XCHG_CODE     = 18;

  typedef enum logic [1:0] {
    HOLD_NONE = 2'd0,
    HOLD_BUS  = 2'd1,
    HOLD_LINE = 2'd2
  } hold_e;

  typedef struct packed {
    logic fault;
    logic grant;
    logic use_line;
  } verdict_t;

  // Operand rule for a prefixed instruction: memory destination, register source.
  function automatic logic operands_ok(logic dst_is_mem, logic src_is_mem);
    return dst_is_mem && !src_is_mem;
  endfunction

  // Implicit locking of the exchange operation when a memory operand exists.
  function automatic logic implicit_grant(logic is_xchg, logic dst_is_mem, logic src_is_mem);
    return is_xchg && (dst_is_mem || src_is_mem);
  endfunction
endpackage

// File: rtl/atomic_lock_judge.sv
module atomic_lock_judge
  import atomic_lock_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic            pfx,
  input  logic            dst_is_mem,
  input  logic            src_is_mem,
  input  logic            cached,
  output verdict_t        verdict
);
  logic [OP_COUNT-1:0] lockable_mask;
  logic [OP_COUNT-1:0] xchg_mask;

  for (genvar i = 0; i < OP_COUNT; i++) begin : g_mask
    assign lockable_mask[i] = (i <= LOCKABLE_LAST);
    assign xchg_mask[i]     = (i == XCHG_CODE);
  end

  logic op_lockable;
  logic op_xchg;
  logic pfx_legal;

  assign op_lockable = lockable_mask[op];
  assign op_xchg     = xchg_mask[op];
  assign pfx_legal   = op_lockable && operands_ok(dst_is_mem, src_is_mem);

  always_comb begin
    verdict = '0;
    if (pfx) begin
      verdict.fault = !pfx_legal;
      verdict.grant = pfx_legal;
    end else begin
      verdict.grant = implicit_grant(op_xchg, dst_is_mem, src_is_mem);
    end
    verdict.use_line = verdict.grant && cached;
  end
endmodule

// File: rtl/atomic_lock_hold.sv
module atomic_lock_hold
  import atomic_lock_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     take,
  input  verdict_t verdict,
  input  logic     retire,
  output hold_e    state,
  output logic     held
);
  hold_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HOLD_NONE;
    end else if (take) begin
      if (verdict.grant)
        state_q <= verdict.use_line ? HOLD_LINE : HOLD_BUS;
      else
        state_q <= HOLD_NONE;
    end else if (retire) begin
      state_q <= HOLD_NONE;
    end
  end

  assign state = state_q;
  assign held  = (state_q != HOLD_NONE);
endmodule

// File: rtl/atomic_lock_ctrl.sv
module atomic_lock_ctrl
  import atomic_lock_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dec_valid,
  output logic            dec_ready,
  input  logic [OP_W-1:0] op_class,
  input  logic            lock_pfx,
  input  logic            dst_mem,
  input  logic            src_mem,
  input  logic            line_cached,
  input  logic [2:0]      cpu_mode,
  input  logic            misaligned,
  input  logic            retire,
  output logic            lock_n,
  output logic            cache_lock,
  output logic            ud_fault
);
  verdict_t verdict;
  hold_e    state;
  logic     held;
  logic     accept;
  logic     ctx_unused;

  // Mode and alignment are deliberately kept out of every decision.
  assign ctx_unused = ^{cpu_mode, misaligned};

  atomic_lock_judge u_judge (
    .op         (op_class),
    .pfx        (lock_pfx),
    .dst_is_mem (dst_mem),
    .src_is_mem (src_mem),
    .cached     (line_cached),
    .verdict    (verdict)
  );

  assign dec_ready = !held || retire;
  assign accept    = dec_valid && dec_ready;

  atomic_lock_hold u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (accept),
    .verdict (verdict),
    .retire  (retire),
    .state   (state),
    .held    (held)
  );

  assign ud_fault   = accept && verdict.fault;
  assign lock_n     = (state != HOLD_BUS);
  assign cache_lock = (state == HOLD_LINE);
endmodule

// File: rtl/atomic_lock_chk.sv
module atomic_lock_chk (
  input logic clk,
  input logic rst_n,
  input logic dec_ready,
  input logic lock_pfx,
  input logic retire,
  input logic lock_n,
  input logic cache_lock,
  input logic ud_fault,
  input logic accept,
  input logic held
);
  p_fault_needs_prefix_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ud_fault |-> (accept && lock_pfx));

  p_fault_no_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ud_fault |=> (lock_n && !cache_lock));

  p_one_lock_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!lock_n && cache_lock));

  p_hold_until_retire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !retire) |=> ($stable(lock_n) && $stable(cache_lock)));

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (held && retire && !accept) |=> (lock_n && !cache_lock));

  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !retire) |-> !dec_ready);

  p_idle_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !held |-> dec_ready);
endmodule

bind atomic_lock_ctrl atomic_lock_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dec_ready  (dec_ready),
  .lock_pfx   (lock_pfx),
  .retire     (retire),
  .lock_n     (lock_n),
  .cache_lock (cache_lock),
  .ud_fault   (ud_fault),
  .accept     (accept),
  .held       (held)
);

// File: tb/atomic_lock_ctrl_test.sv
module atomic_lock_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dec_valid = 1'b0;
  logic       dec_ready;
  logic [4:0] op_class = '0;
  logic       lock_pfx = 1'b0;
  logic       dst_mem = 1'b0;
  logic       src_mem = 1'b0;
  logic       line_cached = 1'b0;
  logic [2:0] cpu_mode = '0;
  logic       misaligned = 1'b0;
  logic       retire = 1'b0;
  logic       lock_n;
  logic       cache_lock;
  logic       ud_fault;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  atomic_lock_ctrl uut (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_ready(dec_ready),
    .op_class(op_class), .lock_pfx(lock_pfx), .dst_mem(dst_mem), .src_mem(src_mem),
    .line_cached(line_cached), .cpu_mode(cpu_mode), .misaligned(misaligned),
    .retire(retire), .lock_n(lock_n), .cache_lock(cache_lock), .ud_fault(ud_fault)
  );

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  endtask

  // Independent restatement of the rules.
  function automatic bit want_fault(int op, bit p, bit d, bit s);
    bit legal_form = (op < 19) && d && !s;
    return p && !legal_form;
  endfunction

  function automatic bit want_lock(int op, bit p, bit d, bit s);
    if (p) return !want_fault(op, p, d, s);
    return (op == 18) && (d || s);
  endfunction

  task automatic run_one(int op, bit p, bit d, bit s, bit c, int mode, bit mis, bit idle_retire);
    bit ef = want_fault(op, p, d, s);
    bit el = want_lock(op, p, d, s);
    @(negedge clk);
    op_class = op[4:0]; lock_pfx = p; dst_mem = d; src_mem = s;
    line_cached = c; cpu_mode = mode[2:0]; misaligned = mis; dec_valid = 1'b1;
    #1;
    chk("R3/R4/R9 fault pulse", int'(ud_fault), int'(ef));
    chk("R10 ready when idle", int'(dec_ready), 1);
    @(negedge clk);
    dec_valid = 1'b0;
    #1;
    chk("R2/R5/R6/R9 bus lock", int'(lock_n), int'(!(el && !c)));
    chk("R2/R5/R6/R9 line lock", int'(cache_lock), int'(el && c));
    chk("R3 fault is single cycle", int'(ud_fault), 0);
    if (el) begin
      repeat (2) @(negedge clk);
      #1;
      chk("R7 lock held", int'(lock_n) + 2*int'(cache_lock), c ? 3 : 0);
      chk("R8 stalled while held", int'(dec_ready), 0);
      retire = 1'b1;
      @(negedge clk);
      retire = 1'b0;
      #1;
      chk("R7 released after retire", int'(lock_n) + 2*int'(cache_lock), 1);
    end else if (idle_retire) begin
      retire = 1'b1;
      @(negedge clk);
      retire = 1'b0;
      #1;
      chk("R10 idle retire ignored", int'(lock_n) + 2*int'(cache_lock) + 4*int'(ud_fault), 1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    #1;
    chk("R1 reset lock_n", int'(lock_n), 1);
    chk("R1 reset cache_lock", int'(cache_lock), 0);
    chk("R1 reset fault", int'(ud_fault), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 ready after reset", int'(dec_ready), 1);
    chk("R1 lock_n after reset", int'(lock_n), 1);

    // Full sweep of class, prefix, operand kinds and cache hint.
    for (int idx = 0; idx < 512; idx++) begin
      int op  = idx & 31;
      bit p   = idx[5];
      bit d   = idx[6];
      bit s   = idx[7];
      bit c   = idx[8];
      run_one(op, p, d, s, c, idx % 5, idx[0] ^ idx[3], idx[2]);
    end

    // Same instruction under every mode and alignment: outcome must not move (R9).
    for (int m = 0; m < 8; m++) begin
      run_one(7, 1'b1, 1'b1, 1'b0, 1'b0, m, m[0], 1'b0);
      run_one(25, 1'b1, 1'b1, 1'b0, 1'b1, m, ~m[0], 1'b0);
    end

    // Coincidence: bus lock held, illegal strobe stalled, then paired with retire.
    @(negedge clk);
    op_class = 5'd3; lock_pfx = 1'b1; dst_mem = 1'b1; src_mem = 1'b0;
    line_cached = 1'b0; dec_valid = 1'b1;
    @(negedge clk);
    op_class = 5'd27; lock_pfx = 1'b1;
    #1;
    chk("R10 stalled strobe no fault", int'(ud_fault), 0);
    chk("R8 not ready while held", int'(dec_ready), 0);
    @(negedge clk);
    #1;
    chk("R7 lock kept during stall", int'(lock_n), 0);
    retire = 1'b1;
    #1;
    chk("R8 ready on retire", int'(dec_ready), 1);
    chk("R3 fault with retire", int'(ud_fault), 1);
    @(negedge clk);
    retire = 1'b0; dec_valid = 1'b0;
    #1;
    chk("R4 released, no lock for faulted", int'(lock_n) + 2*int'(cache_lock), 1);

    // Coincidence: retire of a bus lock together with a cached legal strobe.
    @(negedge clk);
    op_class = 5'd11; lock_pfx = 1'b1; dst_mem = 1'b1; src_mem = 1'b0;
    line_cached = 1'b0; dec_valid = 1'b1;
    @(negedge clk);
    dec_valid = 1'b0;
    @(negedge clk);
    op_class = 5'd18; lock_pfx = 1'b0; dst_mem = 1'b1; line_cached = 1'b1;
    dec_valid = 1'b1; retire = 1'b1;
    @(negedge clk);
    dec_valid = 1'b0; retire = 1'b0;
    #1;
    chk("R8 handover bus to line lock_n", int'(lock_n), 1);
    chk("R8 handover bus to line cache_lock", int'(cache_lock), 1);
    @(negedge clk);
    retire = 1'b1;
    @(negedge clk);
    retire = 1'b0;
    #1;
    chk("R7 final release", int'(lock_n) + 2*int'(cache_lock), 1);

    summary();
  end
endmodule